// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the master end of the two-wire management bus that a MAC uses to reach the configuration and status registers of external physical-layer devices. It produces the management clock itself and runs one serial frame at a time. Each frame reads or writes one 16-bit register. Up to 32 devices can share the line pair, and each device can hold up to 32 registers. The bidirectional data line is split into three signals at the block edge: a driven value, an output enable and a sampled input. The pad logic joins them outside the block.

A host starts a transaction by holding `req_valid` high for a cycle while `busy` is low. The request carries a kind, a device address, a register address and write data. `busy` stays high for the whole frame. `done` pulses for one cycle at the end of the frame. After a read, `rd_data` holds the returned word. The host can also request a resynchronisation frame. When reset is released, the block sends one of these frames before it accepts any request.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is high and the block sends a resynchronisation frame of 32 ones with `mdio_oe` high. It accepts no request until that frame has ended.
- R2: A read or write frame sends its 32 bits most significant bit first, in this order. Start `01`. Opcode `01` for a write or `10` for a read. Five device-address bits. Five register-address bits. Two turnaround bits. Sixteen data bits. On a write the data bits are `req_wdata`.
- R3: `mdc` is low whenever `busy` is low. Let H be `cfg_half`, with 0 treated as 1, sampled when a frame starts (or during reset). During a frame, each bit lasts 2·H system clocks: `mdc` is low for H clocks and then high for H clocks.
- R4: `mdio_o` and `mdio_oe` change only while `mdc` is low, so they are stable across each rising edge of `mdc`.
- R5: On a write, the turnaround bits are driven as `1` then `0`. On a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. Outside a read it is high whenever `busy` is high.
- R6: On a read, `mdio_i` is sampled at the rising `mdc` edge of each of the 16 data bits, first-sampled bit as the most significant bit. The result appears on `rd_data` in the same cycle that `done` is high.
- R7: Write frames and resynchronisation frames leave `rd_data` unchanged.
- R8: A request is taken when `req_valid` is high and `busy` is low. `busy` rises in the next cycle. Requests made while `busy` is high are ignored, including any change to `cfg_half`.
- R9: `done` is high for exactly one cycle, at the edge that ends the last bit's high `mdc` phase, which is 64·H clocks after the frame starts. `busy` falls in that same cycle.
- R10: A request with `req_kind[1]` set sends a resynchronisation frame of 32 ones with `mdio_oe` high. `req_kind` `00` is a write and `01` is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | System clocks per half period of `mdc` (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken only while `busy` is low |
| req_kind | input | 2 | 00 write, 01 read, 1x resynchronisation |
| req_phy | input | 5 | Device address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Word returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value sampled from the data line |

## Verification
The assertions assume that `req_valid` does not assert on its own during reset, and that nothing outside the block needs `mdc` to keep running between frames. The bench meets both assumptions: its stimulus raises requests only after reset, holds `cfg_half` steady while reset is high, and drives `mdio_i` from a device model. That model changes the line only after a falling `mdc` edge and only while the master has released it, so the sampled data is stable at every rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 32;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_W     = 5;
    localparam int TA_FIRST   = 14;
    localparam int DATA_FIRST = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        KIND_WRITE  = 2'b00,
        KIND_READ   = 2'b01,
        KIND_RESYNC = 2'b10,
        KIND_RESYNC2 = 2'b11
    } req_kind_e;

    localparam logic [1:0] SOF_CODE  = 2'b01;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic                  is_read;
    } frame_t;

    function automatic frame_t build_frame(
        input logic [1:0]        kind,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_BITS-1:0] wdata
    );
        frame_t f;
        f.is_read = (kind == KIND_READ);
        if (kind[1]) begin
            f.bits = '1;
        end else if (f.is_read) begin
            f.bits = {SOF_CODE, OPC_READ, phy, regad, 2'b11, {DATA_BITS{1'b1}}};
        end else begin
            f.bits = {SOF_CODE, OPC_WRITE, phy, regad, TA_DRIVE, wdata};
        end
        return f;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cfg,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            half_q <= (half_cfg == '0) ? ONE : half_cfg;
        end
    end

    assign wrap     = run && (cnt_q == half_q - ONE);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || load || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R3: a rising strobe is followed by a high clock, a falling one by a low clock
    assert_rise_gives_high_R3: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && !load) |=> mdc);
    assert_fall_gives_low_R3: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  frame_t               frame,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 mdio_o,
    output logic                 mdio_oe
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_FIRST);
    localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(DATA_FIRST);

    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      bit_q;
    logic                  is_read_q;
    logic [DATA_BITS-1:0]  cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b1;
            sr_q      <= '1;
            is_read_q <= 1'b0;
            bit_q     <= '0;
            done      <= 1'b0;
            cap_q     <= '0;
            rd_data   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                sr_q      <= frame.bits;
                is_read_q <= frame.is_read;
                bit_q     <= '0;
            end else if (busy) begin
                if (rise_stb && is_read_q && bit_q >= DATA_IDX) begin
                    cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
                end
                if (fall_stb) begin
                    if (bit_q == LAST_IDX) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        if (is_read_q) begin
                            rd_data <= cap_q;
                        end
                    end else begin
                        sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
                        bit_q <= bit_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign mdio_o  = busy ? sr_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy && !(is_read_q && bit_q >= TA_IDX);

    // R9: single-cycle done, and every end of busy is marked by done
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R5: the line is released only inside a read frame
    assert_release_only_read_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !mdio_oe) |-> is_read_q);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic   accept;
    logic   rise_stb;
    logic   fall_stb;
    frame_t next_frame;

    assign accept     = req_valid && !busy;
    assign next_frame = build_frame(req_kind, req_phy, req_reg, req_wdata);

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .run      (busy),
        .half_cfg (cfg_half),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame    (next_frame),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // R3: clock parked low between frames
    assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);
    // R8: a frame begins only after a request
    assert_start_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));
    // R4: line value and direction hold while the clock is high
    assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd2;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .req_valid(req_valid),
        .req_kind(req_kind), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    int done_seen = 0;
    int frames_exp = 0;

    // behavioural reference: elapsed-time view of the current frame
    bit          m_ok = 0;
    bit          m_active = 0;
    bit          m_read = 0;
    bit          m_done = 0;
    int          m_t = 0;
    int          m_half = 1;
    logic [31:0] m_frame = '1;
    logic [15:0] m_cap = '0;
    logic [15:0] m_rdata = '0;
    logic [15:0] phy_word = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        m_ok   = 1;
        m_done = 0;
        if (rst) begin
            m_active = 1; m_read = 0; m_t = 0;
            m_half = (cfg_half == 0) ? 1 : int'(cfg_half);
            m_frame = '1; m_rdata = '0; m_cap = '0;
        end else if (m_active) begin
            m_t++;
            if (m_read && (m_t % (2*m_half)) == m_half && (m_t / (2*m_half)) >= 16)
                m_cap = {m_cap[14:0], mdio_i};
            if (m_t == 64*m_half) begin
                m_active = 0; m_done = 1; frames_exp++;
                if (m_read) m_rdata = m_cap;
            end
        end else if (req_valid) begin
            m_active = 1; m_t = 0;
            m_half = (cfg_half == 0) ? 1 : int'(cfg_half);
            m_read = (req_kind == 2'b01);
            if (req_kind[1]) m_frame = '1;
            else if (m_read) m_frame = {2'b01, 2'b10, req_phy, req_reg, 18'h3FFFF};
            else m_frame = {2'b01, 2'b01, req_phy, req_reg, 2'b10, req_wdata};
        end
    end

    // device model drives returned data while the master has released the line
    always @(negedge clk) begin
        int b;
        b = m_t / (2*m_half);
        if (m_active && m_read && b >= 16) mdio_i = phy_word[31-b];
        else mdio_i = 1'b1;
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        int b;
        logic e_mdc, e_oe, e_o;
        if (m_ok && !finished) begin
            b = m_t / (2*m_half);
            e_mdc = m_active ? (((m_t / m_half) % 2) == 1) : 1'b0;
            e_oe  = m_active && !(m_read && b >= 14);
            e_o   = m_active ? m_frame[31 - (b > 31 ? 31 : b)] : 1'b1;
            if (done) done_seen++;
            chk("R8 busy", 32'(busy), 32'(m_active));
            chk("R3 mdc", 32'(mdc), 32'(e_mdc));
            chk("R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) chk("R2 R10 mdio_o", 32'(mdio_o), 32'(e_o));
            chk("R9 done", 32'(done), 32'(m_done));
            chk("R6 R7 rd_data", 32'(rd_data), 32'(m_rdata));
        end
    end

    task automatic summary();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
        end
    end

    task automatic issue(input logic [1:0] kind, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [7:0] half);
        while (m_active) @(negedge clk);
        req_kind = kind; req_phy = phy; req_reg = rg; req_wdata = wd; cfg_half = half;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk("R1 reset busy", 32'(busy), 32'd1);
        chk("R1 reset mdc", 32'(mdc), 32'd0);
        chk("R1 reset oe", 32'(mdio_oe), 32'd1);
        chk("R1 reset mdio_o", 32'(mdio_o), 32'd1);
        chk("R1 reset done", 32'(done), 32'd0);
        rst = 1'b0;
        // R1: a request during the power-up frame is ignored
        req_valid = 1'b1; req_kind = 2'b00; req_wdata = 16'h1234;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R1 power-up frame ended", 32'(done_seen), 32'd1);

        // R2 write, H=2
        issue(2'b00, 5'h11, 5'h0A, 16'hA5C3, 8'd2);
        wait_idle();

        // R6 read, H=3, with R8 stray requests mid-frame
        phy_word = 16'h9C35;
        issue(2'b01, 5'h05, 5'h1B, 16'h0000, 8'd3);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_wdata = 16'hFFFF; cfg_half = 8'd1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R6 read word", 32'(rd_data), 32'h9C35);

        // R3 zero half period acts as one; R7 write keeps rd_data
        issue(2'b00, 5'h1F, 5'h00, 16'hFFFF, 8'd0);
        wait_idle();
        chk("R7 after write", 32'(rd_data), 32'h9C35);

        // R10 resync request
        issue(2'b10, 5'h00, 5'h00, 16'h0000, 8'd1);
        wait_idle();
        chk("R7 after resync", 32'(rd_data), 32'h9C35);

        // boundary reads, back to back
        phy_word = 16'h0001;
        issue(2'b01, 5'h00, 5'h1F, 16'h0000, 8'd1);
        phy_word = 16'h8000;
        issue(2'b01, 5'h1F, 5'h1F, 16'h0000, 8'd4);
        wait_idle();
        chk("R6 msb-only read", 32'(rd_data), 32'h8000);

        issue(2'b11, 5'h00, 5'h00, 16'h0000, 8'd2);
        wait_idle();
        chk("R9 done count", 32'(done_seen), 32'(frames_exp));
        summary();
    end

endmodule